// File: doc/BRIEF.md
# Indirect Pattern Memory Host Port

This block sits between a host register interface and a 128-word pattern memory. Each memory word is 40 bits wide and is made of five bytes. The host sees four register slots, selected by a 2-bit index. Slot 0 is the control register, slots 1 and 2 are data registers, and slot 3 is unused. The control register carries a word address, a mode bit and the first data byte. The two data registers carry the other four bytes.

A host write is staged in three steps and reaches the memory as one 40-bit word, only on the last step. Readback goes through a registered memory read of the latched address. Software therefore reads the word one clock after it sets the address.

Setting the mode bit hands the memory to a matching engine. The engine reads it through a separate asynchronous port. While the mode bit is set, host writes are locked out and host readback is masked.

Top module: `patmem_host_port`

## Requirements
- R1: After a hard reset (rst_n low) the address field and the mode bit are 0 and seq_err is 0. Slot 0 then reads 0 in bits 7:0. The staged data bytes are undefined.
- R2: In normal mode, a slot 0 write latches the address from wdata[6:0], the mode bit from wdata[7] and the staged byte 0 from wdata[15:8]. It also clears seq_err and restarts the write sequence. Slot 0 reads the address in bits 6:0 and the mode bit in bit 7.
- R3: In normal mode, write slot 0, then slot 1, then slot 2. The slot 2 write stores the 40-bit word at the latched address, with byte k in bits 8k+7:8k:
  - byte 0 comes from the slot 0 write, bits 15:8;
  - bytes 1 and 2 come from the slot 1 write, bits 7:0 and 15:8;
  - bytes 3 and 4 come from the slot 2 write, bits 7:0 and 15:8.
  The memory does not change before the slot 2 write.
- R4: In normal mode, from the second clock edge after a slot 0 write the host can read the addressed word. The reads may come in any order:
  - slot 0, bits 15:8, returns byte 0;
  - slot 1 returns {byte 2, byte 1};
  - slot 2 returns {byte 4, byte 3}.
  After a commit, readback shows the new word from the following clock edge.
- R5: A slot 2 write with no slot 1 write since the last slot 0 write or the last commit leaves the memory unchanged and sets seq_err. seq_err stays set until the next slot 0 write in normal mode.
- R6: A slot 0 write with bit 7 set enters matching mode; if the block was in normal mode, the same write also latches the address. In matching mode:
  - slot 1 and slot 2 writes are ignored;
  - slot 0 writes change only the mode bit, so a slot 0 write with bit 7 clear returns to normal mode and keeps the old address.
- R7: In matching mode, slot 0 reads 32'h0000_0080 and every other slot reads 0.
- R8: Bits 31:16 of every read are 0. Slot 3 reads 0, and writes to it are ignored.
- R9: In matching mode, eng_word returns the memory word at eng_addr in the same cycle. In normal mode eng_word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| reg_sel | input | 2 | Register slot index |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected slot |
| seq_err | output | 1 | Set by a slot 2 write that has no slot 1 write before it |
| eng_addr | input | 7 | Engine read address |
| eng_word | output | 40 | Engine read word, 0 in normal mode |

## Verification
The assertions check on every cycle that:
- the reserved upper read bits are zero;
- the engine port is idle in normal mode;
- readback is masked in matching mode;
- the address cannot change in matching mode;
- an out-of-order slot 2 write raises the error flag, and a normal slot 0 write clears it.

Only the bench scenarios can show the contents of the memory: that the five bytes land in the right lanes at the right address, that nothing commits before the final write, that reads in any order return the stored word, and that writes made while locked out leave both the memory and the address unchanged once normal mode returns.

// File: rtl/patmem_host_port.sv
module patmem_host_port #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              seq_err,
  input  logic [ADDR_W-1:0] eng_addr,
  output logic [39:0]       eng_word
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int WORD_W = 40;

  logic [ADDR_W-1:0] addr_q;
  logic              mode_q, lo_seen_q, err_q;
  logic [7:0]        b0_q, b1_q, b2_q;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_q;

  wire unused_wdata = ^reg_wdata[31:16];

  wire wr_ctl = reg_wr && (reg_sel == 2'd0);
  wire wr_lo  = reg_wr && (reg_sel == 2'd1) && !mode_q;
  wire wr_hi  = reg_wr && (reg_sel == 2'd2) && !mode_q;
  wire commit = wr_hi && lo_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      mode_q    <= 1'b0;
      lo_seen_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (wr_ctl) begin
        mode_q <= reg_wdata[7];
        if (!mode_q) begin
          addr_q    <= reg_wdata[ADDR_W-1:0];
          lo_seen_q <= 1'b0;
          err_q     <= 1'b0;
        end
      end
      if (wr_lo) lo_seen_q <= 1'b1;
      if (wr_hi) begin
        lo_seen_q <= 1'b0;
        if (!lo_seen_q) err_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ctl && !mode_q) b0_q <= reg_wdata[15:8];
    if (wr_lo) begin
      b1_q <= reg_wdata[7:0];
      b2_q <= reg_wdata[15:8];
    end
    if (commit) mem[addr_q] <= {reg_wdata[15:8], reg_wdata[7:0], b2_q, b1_q, b0_q};
    rd_q <= mem[addr_q];
  end

  always_comb begin
    reg_rdata = '0;
    if (mode_q) begin
      if (reg_sel == 2'd0) reg_rdata[7] = 1'b1;
    end else begin
      case (reg_sel)
        2'd0:    reg_rdata[15:0] = {rd_q[7:0], 1'b0, addr_q};
        2'd1:    reg_rdata[15:0] = rd_q[23:8];
        2'd2:    reg_rdata[15:0] = rd_q[39:24];
        default: reg_rdata = '0;
      endcase
    end
  end

  assign seq_err  = err_q;
  assign eng_word = mode_q ? mem[eng_addr] : '0;

  assert_seq_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd2 && !mode_q && !lo_seen_q) |=> seq_err);
  assert_ctl_clears_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd0 && !mode_q) |=> !seq_err);
  assert_lock_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> $stable(addr_q));
  assert_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (reg_rdata[31:8] == '0 && reg_rdata[6:0] == '0));
  assert_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:16] == '0);
  assert_eng_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> eng_word == '0);
  assert_mode_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_q) |-> $past(reg_wr && reg_sel == 2'd0));
endmodule

// File: tb/patmem_host_port_bench.sv
`timescale 1ns/1ps
module patmem_host_port_bench;
  logic        clk = 0, rst_n = 0, reg_wr = 0;
  logic [1:0]  reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        seq_err;
  logic [6:0]  eng_addr = 0;
  logic [39:0] eng_word;

  int tests = 0, fails = 0;
  logic [39:0] model [128];

  patmem_host_port u_patmem_host_port (.clk, .rst_n, .reg_sel, .reg_wr, .reg_wdata,
    .reg_rdata, .seq_err, .eng_addr, .eng_word);

  always #2 clk = ~clk;

  function automatic logic [31:0] exp_reg(input logic [1:0] s, input logic [39:0] w, input logic [6:0] a);
    case (s)
      2'd0:    return {16'h0, w[7:0], 1'b0, a};
      2'd1:    return {16'h0, w[23:8]};
      2'd2:    return {16'h0, w[39:24]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); reg_sel = s; #0.5; v = reg_rdata;
  endtask

  task automatic put(input logic [6:0] a, input logic [39:0] w);
    wr(0, {16'h0, w[7:0], 1'b0, a});
    wr(1, {16'h0, w[23:8]});
    wr(2, {16'h0, w[39:24]});
    model[a] = w;
  endtask

  task automatic rd_chk(input logic [1:0] s, input logic [6:0] a, input string tag);
    logic [31:0] v;
    rd(s, v);
    chk(v, exp_reg(s, model[a], a), tag);
  endtask

  initial begin
    #(4.0 * 150000);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, v);
    chk(v[7:0], 0, "R1 reset ctrl");
    chk(seq_err, 0, "R1 reset seq_err");
    chk(eng_word, 0, "R9 idle after reset");

    for (int a = 0; a < 128; a++) put(7'(a), {$urandom, 8'($urandom)});

    wr(0, {16'h0, 8'hA5, 8'h05});
    rd(0, v);
    chk(v[7:0], 8'h05, "R2 address readback");
    wr(1, 32'h0000_1234);
    rd_chk(1, 5, "R3 no commit before last write");
    wr(2, 32'h0000_5678);
    model[5] = 40'h56_78_12_34_A5;
    rd_chk(2, 5, "R3 commit bytes 4:3");
    rd_chk(0, 5, "R4 order byte0");
    rd_chk(1, 5, "R4 order bytes 2:1");

    wr(0, {16'h0, 8'h11, 8'h09});
    wr(2, 32'h0000_FFFF);
    chk(seq_err, 1, "R5 missing slot1 sets flag");
    rd_chk(2, 9, "R5 memory unchanged");
    rd_chk(1, 9, "R5 memory unchanged lo");
    wr(0, {16'h0, 8'h11, 8'h09});
    chk(seq_err, 0, "R5 ctrl clears flag");
    put(7'd9, 40'h01_02_03_04_05);
    wr(2, 32'h0000_EEEE);
    chk(seq_err, 1, "R5 second slot2 after commit");
    rd_chk(2, 9, "R5 no recommit");

    wr(3, 32'h0000_BEEF);
    rd(3, v);
    chk(v, 0, "R8 slot3 reads zero");
    rd_chk(0, 9, "R8 slot3 write ignored");

    for (int i = 0; i < 300; i++) begin
      logic [6:0] a;
      a = 7'($urandom_range(0, 127));
      if ($urandom_range(0, 1) == 1) put(a, {$urandom, 8'($urandom)});
      wr(0, {16'h0, 8'($urandom), 1'b0, a});
      for (int k = 0; k < 3; k++) begin
        logic [1:0] s;
        s = 2'($urandom_range(0, 2));
        rd(s, v);
        chk(v, exp_reg(s, model[a], a), "R4 random readback");
        chk(v[31:16], 0, "R8 reserved bits");
      end
    end

    wr(0, {16'h0, 8'h00, 8'h80 | 8'h21});
    rd(0, v); chk(v, 32'h80, "R7 masked slot0");
    rd(1, v); chk(v, 0, "R7 masked slot1");
    rd(2, v); chk(v, 0, "R7 masked slot2");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); eng_addr = 7'($urandom_range(0, 127)); #0.5;
      chk(eng_word, model[eng_addr], "R9 engine read");
    end
    wr(0, {16'h0, 8'h77, 8'h80 | 8'h40});
    wr(1, 32'h0000_DEAD);
    wr(2, 32'h0000_BEEF);
    @(negedge clk); eng_addr = 7'h21; #0.5;
    chk(eng_word, model[7'h21], "R6 data writes ignored");
    wr(0, {16'h0, 8'h77, 8'h40});
    rd(0, v);
    chk(v[7:0], 8'h21, "R6 address kept on exit");
    rd_chk(1, 7'h21, "R6 memory unchanged");
    rd_chk(2, 7'h21, "R6 memory unchanged hi");
    chk(eng_word, 0, "R9 idle in normal mode");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule